// File: doc/BRIEF.md
# Lane-Partitioned SIMD Arithmetic Logic Unit

This unit performs one arithmetic or logic operation per clock on two 32-bit words. A width-mode input decides whether the word is a single 32-bit value, a pair of 16-bit lanes, or four 8-bit lanes. Add, subtract, AND, OR, XOR and compare are available in every mode. In the narrow modes, carries and borrows stop at each lane edge, so every lane computes the same result it would on a separate narrow unit.

Every lane reports its own zero, negative, carry and overflow flags. A condition select turns those flags into a per-byte write-enable vector. A register file can then store only the lanes that meet the condition. All lanes run the same instruction, but their results differ by lane. This replaces an if-then-else branch with conditional data flow. Results, flags and enables are registered, so they appear one cycle after the operands.

Top module: `simd_lane_alu`

## Requirements
- R1: `width_mode` encoding: 0 selects four 8-bit lanes, 1 selects two 16-bit lanes, 2 and 3 select one 32-bit lane. Lane i occupies bits [W*i+W-1 : W*i], where W is the lane width.
- R2: `opcode` 0 adds and 1 subtracts (A minus B), lane by lane. No carry or borrow crosses a lane boundary.
- R3: `opcode` 2, 3 and 4 give the bitwise AND, OR and XOR. For these operations the carry and overflow flags of every lane are 0.
- R4: `opcode` 5 (compare) returns operand A unchanged as the result. Its flags come from the lane-wise difference A minus B.
- R5: Each lane has a 4-bit flag group {V,C,N,Z} (bit 3 to bit 0):
  - Z is set when the lane value is all zero.
  - N is the lane MSB.
  - C is the lane carry-out; for subtract and compare, C=1 means no borrow.
  - V is signed overflow.
  - The group of a lane that starts at byte s sits at `lane_flags[4*s+3:4*s]`.
  - Opcodes 6 and 7 behave as add.
- R6: Flag slots that hold no lane start (slots 1 and 3 in 16-bit mode, slots 1 to 3 in 32-bit mode) read 0.
- R7: `cond_sel` sets the lane condition:
  - 0 is always.
  - 1 is Z.
  - 2 is not Z.
  - 3 is N.
  - 4 is C.
  - 5 to 7 are never.
- R8: `wr_en[k]` enables byte k and equals the condition of the lane that holds that byte. A 16-bit lane drives both of its byte enables, and 32-bit mode drives all four from one condition.
- R9: A new operation is accepted every cycle. Its result, flags and enables appear on the outputs after the next rising clock edge.
- R10: While `rst_n` is low, `result`, `lane_flags` and `wr_en` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| opcode | input | 3 | Operation select |
| width_mode | input | 2 | Lane partition select |
| cond_sel | input | 3 | Write condition select |
| result | output | 32 | Registered result word |
| lane_flags | output | 16 | Per-lane {V,C,N,Z} groups, one 4-bit slot per byte |
| wr_en | output | 4 | Per-byte conditional write enables |

## Verification
The properties assume that every input is a defined value at each rising edge while reset is released. They also assume that an operation is held for exactly one edge, so that the registered outputs always refer to the inputs of the previous edge. The stimulus changes inputs only on the falling edge and draws every field from its full encoded range, including reserved opcodes and condition codes. Directed cases at lane-edge carries, borrows and signed overflow are added for every width mode.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [2:0]  opcode,
  input  logic [1:0]  width_mode,
  input  logic [2:0]  cond_sel,
  output logic [31:0] result,
  output logic [15:0] lane_flags,
  output logic [3:0]  wr_en
);
  localparam int NB = 4;

  logic m8, m16, is_sub, is_logic, is_cmp;
  logic [NB-1:0] start, co, ov, cnd;
  logic [31:0] bx, sum, res_d, fsrc;
  logic [15:0] flg_d;
  logic [NB-1:0] wr_d;

  assign m8       = (width_mode == 2'd0);
  assign m16      = (width_mode == 2'd1);
  assign is_cmp   = (opcode == 3'd5);
  assign is_sub   = (opcode == 3'd1) || is_cmp;
  assign is_logic = (opcode == 3'd2) || (opcode == 3'd3) || (opcode == 3'd4);
  assign start    = m8 ? 4'b1111 : (m16 ? 4'b0101 : 4'b0001);
  assign bx       = is_sub ? ~op_b : op_b;

  always_comb begin
    logic c;
    logic [8:0] s9;
    c   = 1'b0;
    s9  = '0;
    sum = '0;
    co  = '0;
    ov  = '0;
    for (int k = 0; k < NB; k++) begin
      s9 = {1'b0, op_a[8*k +: 8]} + {1'b0, bx[8*k +: 8]} + {8'd0, start[k] ? is_sub : c};
      sum[8*k +: 8] = s9[7:0];
      c     = s9[8];
      co[k] = s9[8];
      ov[k] = (op_a[8*k+7] == bx[8*k+7]) && (s9[7] != op_a[8*k+7]);
    end
  end

  always_comb begin
    case (opcode)
      3'd2:    res_d = op_a & op_b;
      3'd3:    res_d = op_a | op_b;
      3'd4:    res_d = op_a ^ op_b;
      3'd5:    res_d = op_a;
      default: res_d = sum;
    endcase
  end

  assign fsrc = is_cmp ? sum : res_d;

  always_comb begin
    int t;
    logic z, n, cy, v;
    flg_d = '0;
    cnd   = '0;
    for (int k = 0; k < NB; k++) begin
      t = m8 ? k : (m16 ? k + 1 : NB - 1);
      z = 1'b1;
      for (int j = 0; j < NB; j++)
        if (j >= k && j <= t && fsrc[8*j +: 8] != 8'd0) z = 1'b0;
      n  = fsrc[8*t+7];
      cy = !is_logic && co[t];
      v  = !is_logic && ov[t];
      if (start[k]) begin
        flg_d[4*k +: 4] = {v, cy, n, z};
        case (cond_sel)
          3'd0:    cnd[k] = 1'b1;
          3'd1:    cnd[k] = z;
          3'd2:    cnd[k] = !z;
          3'd3:    cnd[k] = n;
          3'd4:    cnd[k] = cy;
          default: cnd[k] = 1'b0;
        endcase
      end
    end
  end

  for (genvar j = 0; j < NB; j++) begin : g_wr
    localparam int H = j & 2;
    assign wr_d[j] = m8 ? cnd[j] : (m16 ? cnd[H] : cnd[0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result     <= '0;
      lane_flags <= '0;
      wr_en      <= '0;
    end else begin
      result     <= res_d;
      lane_flags <= flg_d;
      wr_en      <= wr_d;
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] op_a,
  input logic [2:0]  opcode,
  input logic [1:0]  width_mode,
  input logic [2:0]  cond_sel,
  input logic [31:0] result,
  input logic [15:0] lane_flags,
  input logic [3:0]  wr_en
);
  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (result == 32'd0 && lane_flags == 16'd0 && wr_en == 4'd0));

  assert_pair_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (width_mode == 2'd1) |=> (wr_en[0] == wr_en[1] && wr_en[2] == wr_en[3]));

  assert_word_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
    width_mode[1] |=> (wr_en == 4'h0 || wr_en == 4'hF));

  assert_always_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 3'd0) |=> (wr_en == 4'hF));

  assert_idle_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
    width_mode[1] |=> (lane_flags[15:4] == 12'd0));

  assert_logic_no_cv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 3'd2 || opcode == 3'd3 || opcode == 3'd4) |=> ((lane_flags & 16'hCCCC) == 16'd0));

  assert_cmp_keeps_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 3'd5) |=> (result == $past(op_a)));
endmodule

bind simd_lane_alu simd_lane_alu_chk i_chk (.*);

// File: tb/test_simd_lane_alu.sv
module test_simd_lane_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [2:0]  opcode = '0, cond_sel = '0;
  logic [1:0]  width_mode = '0;
  logic [31:0] result;
  logic [15:0] lane_flags;
  logic [3:0]  wr_en;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  simd_lane_alu i_simd_lane_alu (.*);

  function automatic void model(input logic [31:0] a, b, input logic [2:0] op,
      input logic [1:0] md, input logic [2:0] cs,
      output logic [31:0] r, output logic [15:0] f, output logic [3:0] w);
    int wd, nl, slot;
    longint unsigned mask, av, bv, bs, sv, rv, fv;
    bit sub, arith, cy, vf, z, nn, cc;
    wd = (md == 0) ? 8 : (md == 1) ? 16 : 32;
    nl = 32 / wd;
    mask = (64'd1 << wd) - 1;
    sub = (op == 1) || (op == 5);
    arith = !(op == 2 || op == 3 || op == 4);
    r = '0; f = '0; w = '0;
    for (int i = 0; i < nl; i++) begin
      av = (longint'(a) >> (i*wd)) & mask;
      bv = (longint'(b) >> (i*wd)) & mask;
      bs = sub ? ((~bv) & mask) : bv;
      sv = av + bs + (sub ? 1 : 0);
      cy = arith && (((sv >> wd) & 1) == 1);
      vf = arith && (((av >> (wd-1)) & 1) == ((bs >> (wd-1)) & 1))
                 && (((sv >> (wd-1)) & 1) != ((av >> (wd-1)) & 1));
      case (op)
        3'd2: rv = av & bv;
        3'd3: rv = av | bv;
        3'd4: rv = av ^ bv;
        3'd5: rv = av;
        default: rv = sv & mask;
      endcase
      fv = (op == 5) ? (sv & mask) : rv;
      z = (fv == 0);
      nn = ((fv >> (wd-1)) & 1) == 1;
      case (cs)
        3'd0: cc = 1;
        3'd1: cc = z;
        3'd2: cc = !z;
        3'd3: cc = nn;
        3'd4: cc = cy;
        default: cc = 0;
      endcase
      slot = i * wd / 8;
      f[4*slot +: 4] = {vf, cy, nn, z};
      for (int j = 0; j < wd/8; j++) w[slot + j] = cc;
      r = r | 32'(rv << (i*wd));
    end
  endfunction

  task automatic run_op(input logic [31:0] a, b, input logic [2:0] op,
      input logic [1:0] md, input logic [2:0] cs, input string req);
    logic [31:0] er; logic [15:0] ef; logic [3:0] ew;
    op_a = a; op_b = b; opcode = op; width_mode = md; cond_sel = cs;
    model(a, b, op, md, cs, er, ef, ew);
    @(negedge clk);
    n_chk++;
    if (result !== er || lane_flags !== ef || wr_en !== ew) begin
      n_fail++;
      $display("FAIL %s: op=%0d mode=%0d cond=%0d a=%h b=%h actual r=%h f=%h w=%h expected r=%h f=%h w=%h",
        req, op, md, cs, a, b, result, lane_flags, wr_en, er, ef, ew);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [31:0] ra, rb;
    seed = 32'd7;
    void'($urandom(seed));
    op_a = 32'hDEADBEEF; op_b = 32'h12345678; opcode = 3'd0; cond_sel = 3'd0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (result !== 0 || lane_flags !== 0 || wr_en !== 0) begin
      n_fail++;
      $display("FAIL R10: actual r=%h f=%h w=%h expected all zero", result, lane_flags, wr_en);
    end
    rst_n = 1'b1;
    // R2: byte carries must not ripple into the next byte
    run_op(32'hFF01FF80, 32'h01FF0180, 3'd0, 2'd0, 3'd4, "R2");
    run_op(32'h0000FFFF, 32'h00000001, 3'd0, 2'd1, 3'd1, "R2");
    run_op(32'h0000FFFF, 32'h00000001, 3'd0, 2'd2, 3'd1, "R1");
    run_op(32'h00100000, 32'h00010001, 3'd1, 2'd1, 3'd4, "R2");
    run_op(32'h00010203, 32'h01010101, 3'd1, 2'd0, 3'd3, "R2");
    // R5: signed overflow per width
    run_op(32'h7FFFFFFF, 32'h00000001, 3'd0, 2'd3, 3'd3, "R5");
    run_op(32'h7FFF8000, 32'h0001FFFF, 3'd0, 2'd1, 3'd0, "R5");
    run_op(32'h807F7F80, 32'h01FF01FF, 3'd1, 2'd0, 3'd2, "R5");
    run_op(32'h12345678, 32'h00000000, 3'd6, 2'd0, 3'd0, "R5");
    // R3 logic ops
    run_op(32'hF0F0FFFF, 32'hFF00FFFF, 3'd2, 2'd0, 3'd3, "R3");
    run_op(32'hAAAA0000, 32'h55550000, 3'd3, 2'd1, 3'd1, "R3");
    run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 3'd4, 2'd2, 3'd1, "R3");
    // R4 compare
    run_op(32'h05050505, 32'h05060405, 3'd5, 2'd0, 3'd1, "R4");
    run_op(32'h00030005, 32'h00040005, 3'd5, 2'd1, 3'd4, "R4");
    // R6, R7, R8 condition and enable mapping
    run_op(32'h00000000, 32'h00000000, 3'd0, 2'd2, 3'd1, "R6");
    run_op(32'h00000000, 32'h00000000, 3'd0, 2'd0, 3'd6, "R7");
    run_op(32'h00000000, 32'h00000000, 3'd0, 2'd0, 3'd0, "R7");
    run_op(32'h80000001, 32'h00000000, 3'd0, 2'd1, 3'd3, "R8");
    run_op(32'h00010000, 32'h00000000, 3'd0, 2'd1, 3'd2, "R8");
    // R9 back-to-back random operations
    for (int i = 0; i < 600; i++) begin
      ra = $urandom; rb = $urandom;
      if (i % 5 == 0) rb = ra;
      if (i % 7 == 0) rb = ~ra;
      run_op(ra, rb, 3'($urandom), 2'($urandom), 3'($urandom), "R9");
    end
    // R10 reset mid-stream
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    n_chk++;
    if (result !== 0 || lane_flags !== 0 || wr_en !== 0) begin
      n_fail++;
      $display("FAIL R10: actual r=%h f=%h w=%h expected all zero", result, lane_flags, wr_en);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule